// File: doc/BRIEF.md
# Transmit Underflow Recovery Controller

This block decides what a transmitter does after its data FIFO runs dry in the middle of a frame. A configuration bit selects the policy. In halt mode the transmitter is switched off and stays off until software issues a start command. In recovery mode the transmitter stays enabled. The controller then abandons the damaged frame and reads transmit descriptors one by one, starting after the one that failed. It stops at the first descriptor that marks the beginning of a frame and requests a new frame from there.

Descriptors are fetched over a small request/response port. The controller raises a one-cycle request with a ring index, and the answer returns some cycles later with an ownership bit and a start-of-frame bit. The ring index wraps from the last entry back to zero. When the scan reaches a frame start that the controller does not own, it waits, issuing no requests, until a poll command tells it to look again. Every underflow sets a sticky error flag, whichever policy is selected.

Top module: `tx_uflo_recover`

## Requirements
- R1: After `rst`, `tx_on`, `uflo_err`, `cfg_no_stop`, `desc_req`, `adv_req` and `frame_start` are all 0.
- R2: `tx_on` goes from 0 to 1 only in the cycle after a `start_cmd` pulse. Poll commands and underflows never turn it on.
- R3: With `cfg_no_stop` = 0, an underflow while running clears `tx_on` in the next cycle, and no descriptor request follows.
- R4: With `cfg_no_stop` = 1, an underflow leaves `tx_on` at 1 for the whole recovery scan.
- R5: The scan begins at index `ufl_idx`+1, wrapping from RING_LEN-1 to 0. `adv_req` pulses once for every index step, including the first step off the failed descriptor.
- R6: A descriptor answered with `desc_rsp_sop` = 0 is skipped, whatever its ownership bit. The scan then requests the next index.
- R7: A descriptor answered with `desc_rsp_sop` = 1 and `desc_rsp_own` = 1 ends the scan. `frame_start` pulses for exactly one cycle, and `desc_idx` holds that descriptor's index.
- R8: A descriptor answered with `desc_rsp_sop` = 1 and `desc_rsp_own` = 0 parks the controller with no further requests. A `poll_req` pulse makes it read the same index again.
- R9: Every underflow sets `uflo_err` in the next cycle, in either mode. The flag is cleared by `rst`, by `soft_rst`, or by a `start_cmd` issued while halted.
- R10: `cfg_no_stop` is written through `cfg_wr`/`cfg_wr_val` and cleared by `rst` or `soft_rst`. `stop_cmd` halts the transmitter but leaves `cfg_no_stop` unchanged.
- R11: `desc_req` is a one-cycle pulse, and only one request is outstanding at a time. `desc_idx` is stable from the request until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Synchronous software reset, active high |
| cfg_wr | input | 1 | Write strobe for the no-stop configuration bit |
| cfg_wr_val | input | 1 | Value written to the no-stop bit |
| cfg_no_stop | output | 1 | Current no-stop bit (1 = recover on underflow) |
| start_cmd | input | 1 | Start pulse; turns a halted transmitter on |
| stop_cmd | input | 1 | Stop pulse; halts the transmitter from any state |
| poll_req | input | 1 | Poll pulse; re-reads a parked frame-start descriptor |
| ufl_evt | input | 1 | Underflow event pulse |
| ufl_idx | input | IDX_W | Ring index of the descriptor that underflowed |
| desc_req | output | 1 | Descriptor read request pulse |
| desc_idx | output | IDX_W | Ring index being scanned |
| desc_rsp_valid | input | 1 | Descriptor response valid |
| desc_rsp_own | input | 1 | Response ownership bit (1 = controller owns) |
| desc_rsp_sop | input | 1 | Response start-of-frame bit |
| tx_on | output | 1 | Transmitter enabled |
| adv_req | output | 1 | One-cycle pulse per ring index step |
| frame_start | output | 1 | One-cycle pulse: begin the frame at `desc_idx` |
| uflo_err | output | 1 | Sticky underflow error flag |

## Verification
The assertions assume that `desc_rsp_valid` is raised at least one cycle after `desc_req`, only once per request, and only while a request is outstanding. They also assume that the start, stop, poll and underflow inputs are single-cycle pulses. The bench's responder model follows these rules. It answers each request with a random latency of one to three cycles, taking the answer from a ring image the bench holds. It never answers while the controller is parked. Each random ring contains at least one frame start, so every scan ends.

// File: rtl/tx_uflo_pkg.sv
package tx_uflo_pkg;

    typedef enum logic [2:0] {
        ST_HALT  = 3'd0,
        ST_RUN   = 3'd1,
        ST_FETCH = 3'd2,
        ST_WAIT  = 3'd3,
        ST_PARK  = 3'd4
    } ctl_state_t;

    typedef struct packed {
        logic own;
        logic sop;
    } desc_info_t;

    typedef enum logic [1:0] {
        DEC_SKIP  = 2'd0,
        DEC_TAKE  = 2'd1,
        DEC_PARK  = 2'd2
    } scan_dec_t;

    function automatic int unsigned ring_next(input int unsigned cur, input int unsigned len);
        return (cur + 1 >= len) ? 0 : cur + 1;
    endfunction

    function automatic scan_dec_t classify(input desc_info_t d);
        if (!d.sop)
            return DEC_SKIP;
        else if (d.own)
            return DEC_TAKE;
        else
            return DEC_PARK;
    endfunction

endpackage

// File: rtl/tx_uflo_cfg.sv
module tx_uflo_cfg (
    input  logic clk,
    input  logic clr,
    input  logic wr,
    input  logic wr_val,
    input  logic stop_cmd,
    output logic no_stop
);
    logic no_stop_q;

    always_ff @(posedge clk) begin
        if (clr)
            no_stop_q <= 1'b0;
        else if (wr)
            no_stop_q <= wr_val;
    end

    assign no_stop = no_stop_q;

    // R10
    cfg_clear_chk: assert property (@(posedge clk) clr |=> !no_stop_q);

    // R10
    cfg_stop_keep_chk: assert property (@(posedge clk) disable iff (clr)
        (stop_cmd && !wr) |=> $stable(no_stop_q));

endmodule

// File: rtl/tx_uflo_ring_idx.sv
module tx_uflo_ring_idx #(
    parameter int RING_LEN = 8,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [IDX_W-1:0] base,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    import tx_uflo_pkg::*;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] from_base;
    logic [IDX_W-1:0] from_cur;

    always_comb begin
        from_base = IDX_W'(ring_next(int'(base), RING_LEN));
        from_cur  = IDX_W'(ring_next(int'(idx_q), RING_LEN));
    end

    always_ff @(posedge clk) begin
        if (clr)
            idx_q <= '0;
        else if (load)
            idx_q <= from_base;
        else if (step)
            idx_q <= from_cur;
    end

    assign idx = idx_q;

    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (clr)
        int'(idx_q) < RING_LEN);

    // R5
    idx_wrap_chk: assert property (@(posedge clk) disable iff (clr)
        (step && !load && int'(idx_q) == RING_LEN - 1) |=> idx_q == '0);

endmodule

// File: rtl/tx_uflo_fsm.sv
module tx_uflo_fsm (
    input  logic                    clk,
    input  logic                    clr,
    input  logic                    start_cmd,
    input  logic                    stop_cmd,
    input  logic                    poll_req,
    input  logic                    ufl_evt,
    input  logic                    no_stop,
    input  logic                    rsp_valid,
    input  tx_uflo_pkg::desc_info_t rsp,
    output logic                    load_c,
    output logic                    step_c,
    output logic                    tx_on,
    output logic                    desc_req,
    output logic                    adv_pulse,
    output logic                    start_pulse,
    output logic                    err
);
    import tx_uflo_pkg::*;

    ctl_state_t st_q, st_d;
    scan_dec_t  dec;
    logic       adv_q, start_q, err_q;
    logic       take_c;

    always_comb begin
        dec    = classify(rsp);
        st_d   = st_q;
        load_c = 1'b0;
        step_c = 1'b0;
        take_c = 1'b0;
        if (stop_cmd) begin
            st_d = ST_HALT;
        end else begin
            unique case (st_q)
                ST_HALT: if (start_cmd) st_d = ST_RUN;
                ST_RUN: begin
                    if (ufl_evt) begin
                        if (no_stop) begin
                            st_d   = ST_FETCH;
                            load_c = 1'b1;
                        end else begin
                            st_d = ST_HALT;
                        end
                    end
                end
                ST_FETCH: st_d = ST_WAIT;
                ST_WAIT: begin
                    if (rsp_valid) begin
                        unique case (dec)
                            DEC_SKIP: begin
                                st_d   = ST_FETCH;
                                step_c = 1'b1;
                            end
                            DEC_TAKE: begin
                                st_d   = ST_RUN;
                                take_c = 1'b1;
                            end
                            default: st_d = ST_PARK;
                        endcase
                    end
                end
                ST_PARK: if (poll_req) st_d = ST_FETCH;
                default: st_d = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            st_q    <= ST_HALT;
            adv_q   <= 1'b0;
            start_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            adv_q   <= load_c | step_c;
            start_q <= take_c;
            if (ufl_evt)
                err_q <= 1'b1;
            else if (st_q == ST_HALT && start_cmd && !stop_cmd)
                err_q <= 1'b0;
        end
    end

    assign tx_on       = (st_q != ST_HALT);
    assign desc_req    = (st_q == ST_FETCH);
    assign adv_pulse   = adv_q;
    assign start_pulse = start_q;
    assign err         = err_q;

    // R2
    txon_rise_chk: assert property (@(posedge clk) disable iff (clr)
        $rose(tx_on) |-> $past(start_cmd));

    // R3
    halt_on_ufl_chk: assert property (@(posedge clk) disable iff (clr)
        (st_q == ST_RUN && ufl_evt && !no_stop) |=> (!tx_on && !desc_req));

    // R4
    recover_keeps_on_chk: assert property (@(posedge clk) disable iff (clr)
        (st_q == ST_RUN && ufl_evt && no_stop && !stop_cmd) |=> tx_on);

    // R7
    start_single_chk: assert property (@(posedge clk) disable iff (clr)
        start_pulse |=> !start_pulse);

    // R8
    park_quiet_chk: assert property (@(posedge clk) disable iff (clr)
        (st_q == ST_PARK && !poll_req) |=> !desc_req);

    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (clr)
        ufl_evt |=> err);

    // R11
    req_pulse_chk: assert property (@(posedge clk) disable iff (clr)
        desc_req |=> !desc_req);

endmodule

// File: rtl/tx_uflo_recover.sv
module tx_uflo_recover #(
    parameter int RING_LEN = 8,
    localparam int IDX_W   = (RING_LEN > 2) ? $clog2(RING_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             cfg_wr,
    input  logic             cfg_wr_val,
    output logic             cfg_no_stop,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic             poll_req,
    input  logic             ufl_evt,
    input  logic [IDX_W-1:0] ufl_idx,
    output logic             desc_req,
    output logic [IDX_W-1:0] desc_idx,
    input  logic             desc_rsp_valid,
    input  logic             desc_rsp_own,
    input  logic             desc_rsp_sop,
    output logic             tx_on,
    output logic             adv_req,
    output logic             frame_start,
    output logic             uflo_err
);
    import tx_uflo_pkg::*;

    logic       clr;
    logic       no_stop;
    logic       load_c, step_c;
    desc_info_t rsp;

    assign clr = rst | soft_rst;
    assign rsp = '{own: desc_rsp_own, sop: desc_rsp_sop};

    tx_uflo_cfg u_cfg (
        .clk      (clk),
        .clr      (clr),
        .wr       (cfg_wr),
        .wr_val   (cfg_wr_val),
        .stop_cmd (stop_cmd),
        .no_stop  (no_stop)
    );

    tx_uflo_fsm u_fsm (
        .clk         (clk),
        .clr         (clr),
        .start_cmd   (start_cmd),
        .stop_cmd    (stop_cmd),
        .poll_req    (poll_req),
        .ufl_evt     (ufl_evt),
        .no_stop     (no_stop),
        .rsp_valid   (desc_rsp_valid),
        .rsp         (rsp),
        .load_c      (load_c),
        .step_c      (step_c),
        .tx_on       (tx_on),
        .desc_req    (desc_req),
        .adv_pulse   (adv_req),
        .start_pulse (frame_start),
        .err         (uflo_err)
    );

    tx_uflo_ring_idx #(
        .RING_LEN (RING_LEN),
        .IDX_W    (IDX_W)
    ) u_idx (
        .clk  (clk),
        .clr  (clr),
        .load (load_c),
        .base (ufl_idx),
        .step (step_c),
        .idx  (desc_idx)
    );

    assign cfg_no_stop = no_stop;

    // R11
    idx_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (!tx_on || !desc_rsp_valid) && !desc_req && !adv_req && $past(!desc_req) && !ufl_evt
        |=> $stable(desc_idx) || adv_req);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!tx_on && !uflo_err && !desc_req && !frame_start && !adv_req));

endmodule

// File: tb/tx_uflo_recover_test.sv
module tx_uflo_recover_test;
    localparam int RL = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, soft_rst = 1'b0, cfg_wr = 1'b0, cfg_wr_val = 1'b0;
    logic start_cmd = 1'b0, stop_cmd = 1'b0, poll_req = 1'b0, ufl_evt = 1'b0;
    logic [IW-1:0] ufl_idx = '0;
    logic desc_rsp_valid = 1'b0, desc_rsp_own = 1'b0, desc_rsp_sop = 1'b0;
    logic cfg_no_stop, desc_req, tx_on, adv_req, frame_start, uflo_err;
    logic [IW-1:0] desc_idx;

    tx_uflo_recover #(.RING_LEN(RL)) uut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_wr(cfg_wr), .cfg_wr_val(cfg_wr_val),
        .cfg_no_stop(cfg_no_stop), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .poll_req(poll_req), .ufl_evt(ufl_evt), .ufl_idx(ufl_idx), .desc_req(desc_req),
        .desc_idx(desc_idx), .desc_rsp_valid(desc_rsp_valid), .desc_rsp_own(desc_rsp_own),
        .desc_rsp_sop(desc_rsp_sop), .tx_on(tx_on), .adv_req(adv_req),
        .frame_start(frame_start), .uflo_err(uflo_err)
    );

    bit ring_own [RL];
    bit ring_sop [RL];
    int n_chk = 0, n_bad = 0;
    int req_cnt, rsp_cnt, adv_cnt, fs_cnt, fs_idx, txlow_cnt, pend;
    int lat_idx;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        req_cnt = 0; rsp_cnt = 0; adv_cnt = 0; fs_cnt = 0; fs_idx = -1; txlow_cnt = 0;
    endtask

    // descriptor memory model and output monitor
    initial pend = 0;
    always @(negedge clk) begin
        desc_rsp_valid <= 1'b0;
        if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                desc_rsp_valid <= 1'b1;
                desc_rsp_own   <= ring_own[lat_idx];
                desc_rsp_sop   <= ring_sop[lat_idx];
                rsp_cnt++;
            end
        end
        if (desc_req) begin
            req_cnt++;
            lat_idx = int'(desc_idx);
            pend = 1 + int'($urandom % 3);
        end
        if (adv_req) adv_cnt++;
        if (frame_start) begin
            fs_cnt++;
            fs_idx = int'(desc_idx);
        end
        if (!tx_on) txlow_cnt++;
    end

    function automatic int first_sop(input int s);
        for (int k = 0; k < RL; k++)
            if (ring_sop[(s + k) % RL]) return (s + k) % RL;
        return -1;
    endfunction

    task automatic pulse_start();
        start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
    endtask

    task automatic recover_trial(input int u);
        int s, i, steps;
        s = (u + 1) % RL;
        i = first_sop(s);
        steps = (i - s + RL) % RL;
        clear_counts();
        ufl_idx = IW'(u);
        ufl_evt = 1'b1;
        @(negedge clk);
        ufl_evt = 1'b0;
        chk(tx_on == 1'b1, "R4 tx_on after underflow", int'(tx_on), 1);
        chk(uflo_err == 1'b1, "R9 error set in recovery mode", int'(uflo_err), 1);
        if (!ring_own[i]) begin
            for (int k = 0; k < 300 && rsp_cnt < steps + 1; k++) @(negedge clk);
            repeat (5) @(negedge clk);
            chk(req_cnt == steps + 1, "R8 no requests while parked", req_cnt, steps + 1);
            chk(fs_cnt == 0, "R8 no frame start while parked", fs_cnt, 0);
            ring_own[i] = 1'b1;
            poll_req = 1'b1;
            @(negedge clk);
            poll_req = 1'b0;
        end
        for (int k = 0; k < 300 && fs_cnt == 0; k++) @(negedge clk);
        @(negedge clk);
        chk(fs_cnt == 1, "R7 single frame_start pulse", fs_cnt, 1);
        chk(fs_idx == i, "R7 frame_start index", fs_idx, i);
        chk(int'(desc_idx) == i, "R7 desc_idx holds frame start", int'(desc_idx), i);
        chk(adv_cnt == steps + 1, "R5 adv_req pulses", adv_cnt, steps + 1);
        chk(req_cnt == rsp_cnt, "R11 one response per request", rsp_cnt, req_cnt);
        chk(txlow_cnt == 0, "R4 tx_on held during scan", txlow_cnt, 0);
        chk(tx_on == 1'b1, "R7 running after frame start", int'(tx_on), 1);
    endtask

    task automatic main();
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(tx_on == 1'b0, "R1 tx_on", int'(tx_on), 0);
        chk(uflo_err == 1'b0, "R1 uflo_err", int'(uflo_err), 0);
        chk(cfg_no_stop == 1'b0, "R1 cfg_no_stop", int'(cfg_no_stop), 0);
        chk(desc_req == 1'b0 && frame_start == 1'b0 && adv_req == 1'b0, "R1 pulses idle",
            int'({desc_req, frame_start, adv_req}), 0);

        // R2 poll and underflow do not turn the transmitter on
        poll_req = 1'b1; ufl_evt = 1'b1; @(negedge clk); poll_req = 1'b0; ufl_evt = 1'b0;
        @(negedge clk);
        chk(tx_on == 1'b0, "R2 stays off without start", int'(tx_on), 0);
        chk(uflo_err == 1'b1, "R9 error set while halted", int'(uflo_err), 1);
        pulse_start();
        chk(tx_on == 1'b1, "R2 start turns on", int'(tx_on), 1);
        chk(uflo_err == 1'b0, "R9 start clears error", int'(uflo_err), 0);

        // R3 halt mode
        clear_counts();
        ufl_idx = 3'd2; ufl_evt = 1'b1; @(negedge clk); ufl_evt = 1'b0;
        chk(tx_on == 1'b0, "R3 halt on underflow", int'(tx_on), 0);
        chk(uflo_err == 1'b1, "R9 error set in halt mode", int'(uflo_err), 1);
        poll_req = 1'b1; @(negedge clk); poll_req = 1'b0;
        repeat (4) @(negedge clk);
        chk(req_cnt == 0, "R3 no descriptor requests", req_cnt, 0);
        chk(tx_on == 1'b0, "R2 poll does not restart", int'(tx_on), 0);
        pulse_start();
        chk(tx_on == 1'b1, "R2 restart after halt", int'(tx_on), 1);

        // R10 configuration and stop
        cfg_wr = 1'b1; cfg_wr_val = 1'b1; @(negedge clk); cfg_wr = 1'b0;
        chk(cfg_no_stop == 1'b1, "R10 cfg write", int'(cfg_no_stop), 1);
        stop_cmd = 1'b1; @(negedge clk); stop_cmd = 1'b0;
        chk(tx_on == 1'b0, "R10 stop halts", int'(tx_on), 0);
        chk(cfg_no_stop == 1'b1, "R10 stop keeps cfg", int'(cfg_no_stop), 1);
        pulse_start();

        // directed: wrap from last entry to index 0 (R5)
        for (int k = 0; k < RL; k++) begin ring_own[k] = 1'b1; ring_sop[k] = (k == 0); end
        recover_trial(RL - 1);
        // directed: only frame start is the failed entry, full lap, owned non-starts skipped (R6)
        for (int k = 0; k < RL; k++) begin ring_own[k] = 1'b1; ring_sop[k] = (k == 3); end
        recover_trial(3);
        chk(rsp_cnt == RL, "R6 every non-start entry read and skipped", rsp_cnt, RL);
        // directed: unowned frame start parks (R8)
        for (int k = 0; k < RL; k++) begin ring_own[k] = (k != 5); ring_sop[k] = (k == 5); end
        recover_trial(1);

        // random rings
        for (int t = 0; t < 40; t++) begin
            for (int k = 0; k < RL; k++) begin
                ring_own[k] = bit'($urandom % 2);
                ring_sop[k] = ($urandom % 3 == 0);
            end
            ring_sop[$urandom % RL] = 1'b1;
            recover_trial(int'($urandom % RL));
        end

        // R10 soft reset clears cfg and error
        ufl_idx = 3'd0; ufl_evt = 1'b1; @(negedge clk); ufl_evt = 1'b0;
        for (int k = 0; k < 300 && (desc_req || uut.tx_on == 1'b0); k++) @(negedge clk);
        soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
        chk(cfg_no_stop == 1'b0, "R10 soft reset clears cfg", int'(cfg_no_stop), 0);
        chk(uflo_err == 1'b0, "R9 soft reset clears error", int'(uflo_err), 0);
        chk(tx_on == 1'b0, "R10 soft reset halts", int'(tx_on), 0);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        fork
            main();
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule